// File: doc/BRIEF.md
# Snooping MSI Line-State Controller with Pending-Grant States

This block keeps the coherence state of every line of a small direct-mapped, write-back cache that shares a snooping bus with other caches and uses invalidation. Each line is Invalid, Shared or Modified. There are also three waiting states for a line whose bus request has been raised but not yet granted. These are: going from Invalid to Shared, going from Invalid to Modified, and upgrading from Shared to Modified.

The processor side presents one request at a time: a line index and a read/write flag. Hits complete with no bus activity. A miss or an upgrade raises `bus_req` and holds it until `bus_gnt`. In the cycle after the grant, the block issues the bus command, settles the line and signals completion. While the grant is outstanding, `cpu_stall` is high and new processor requests are ignored. Snooped transactions from other caches are still applied every cycle, to any line. A Modified line that is snooped answers with a writeback on the same issue port. A pending upgrade that loses its Shared copy becomes a read-exclusive miss.

Bus command encoding, used on both `iss_cmd` and `snp_cmd`:
- 0 = read
- 1 = read-exclusive
- 2 = invalidate
- 3 = writeback

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid; `bus_req`, `cpu_stall`, `cpu_done` and `iss_vld` are 0.
- R2: A read to an Invalid line raises `bus_req`; on grant the block issues command 0 (read) for that index and the line becomes Shared.
- R3: A write to an Invalid line raises `bus_req`; on grant the block issues command 1 (read-exclusive) and the line becomes Modified.
- R4: A write to a Shared line raises `bus_req`; on grant the block issues command 2 (invalidate) and the line becomes Modified.
- R5: A read to a Shared or Modified line, or a write to a Modified line, pulses `cpu_done` the next cycle with no `bus_req` and no issue.
- R6: A snooped read (0) on a Modified line issues command 3 (writeback) for that index the next cycle and leaves the line Shared. A snooped read-exclusive (1) or invalidate (2) on a Modified line issues the writeback and leaves it Invalid.
- R7: A snooped read-exclusive or invalidate on a Shared line makes it Invalid with no issue. A snooped read leaves it Shared.
- R8: A snooped read-exclusive or invalidate on a line waiting to upgrade turns the wait into an Invalid-to-Modified wait, so the grant then issues command 1.
- R9: While a grant is pending, `cpu_stall` is 1 and processor requests are ignored. Snoops to any line are still applied.
- R10: A snooped writeback changes no line. Snoops leave lines waiting to leave Invalid unchanged.
- R11: `bus_req` stays high until the grant. `iss_vld` and `cpu_done` both pulse in the cycle after the grant. A snoop in the same cycle as a processor request is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IW | Line index of the request |
| cpu_stall | output | 1 | Request pending; new requests ignored |
| cpu_done | output | 1 | Request completed (pulse) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; never in a snoop cycle |
| iss_vld | output | 1 | Issued bus command valid |
| iss_cmd | output | 2 | Issued command code |
| iss_idx | output | IW | Line index of the issued command |
| snp_vld | input | 1 | Snooped transaction valid |
| snp_cmd | input | 2 | Snooped command code |
| snp_idx | input | IW | Snooped line index |

## Verification
Directed sequences walk each line through misses, upgrades and hits. Because the block exposes no state output, each line's state is inferred from what the next request does: a hit, an invalidate or a read-exclusive. Snoops are placed on Modified, Shared and every waiting state, and also on other lines during a wait. This separates correct downgrades from both missed and spurious writebacks, and it separates the upgrade-to-miss conversion from a plain upgrade. A seeded random phase then mixes requests, grants and snoops of all four codes over a few lines, including snoops that land in the same cycle as a request. A reference model checks every cycle, which exposes mistakes in the order of snoop and request handling.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int LINES = 16,
  parameter int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [IW-1:0] cpu_idx,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          iss_vld,
  output logic [1:0]    iss_cmd,
  output logic [IW-1:0] iss_idx,
  input  logic          snp_vld,
  input  logic [1:0]    snp_cmd,
  input  logic [IW-1:0] snp_idx
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_M = 3'd2,
                         ST_IS = 3'd3, ST_IM = 3'd4, ST_SM = 3'd5;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

  logic [2:0]    st [LINES];
  logic [2:0]    nx [LINES];
  logic          pending, pend_n;
  logic [IW-1:0] pidx, pidx_n;
  logic          done_n, iss_n;
  logic [1:0]    cmd_n;
  logic [IW-1:0] idx_n;
  logic          kill;

  assign cpu_stall = pending;
  assign bus_req   = pending;
  assign kill      = (snp_cmd == C_RDX) || (snp_cmd == C_INV);

  always_comb begin
    for (int i = 0; i < LINES; i++) nx[i] = st[i];
    pend_n = pending;
    pidx_n = pidx;
    done_n = 1'b0;
    iss_n  = 1'b0;
    cmd_n  = C_RD;
    idx_n  = pidx;
    if (snp_vld && snp_cmd != C_WB) begin
      case (st[snp_idx])
        ST_M: begin
          iss_n = 1'b1;
          cmd_n = C_WB;
          idx_n = snp_idx;
          nx[snp_idx] = kill ? ST_I : ST_S;
        end
        ST_S:  if (kill) nx[snp_idx] = ST_I;
        ST_SM: if (kill) nx[snp_idx] = ST_IM;
        default: ;
      endcase
    end
    if (pending && bus_gnt) begin
      pend_n = 1'b0;
      done_n = 1'b1;
      iss_n  = 1'b1;
      idx_n  = pidx;
      case (nx[pidx])
        ST_IS:   begin cmd_n = C_RD;  nx[pidx] = ST_S; end
        ST_SM:   begin cmd_n = C_INV; nx[pidx] = ST_M; end
        default: begin cmd_n = C_RDX; nx[pidx] = ST_M; end
      endcase
    end else if (cpu_req && !pending) begin
      case (nx[cpu_idx])
        ST_M: done_n = 1'b1;
        ST_S: begin
          if (cpu_wr) begin
            nx[cpu_idx] = ST_SM;
            pend_n = 1'b1;
            pidx_n = cpu_idx;
          end else done_n = 1'b1;
        end
        default: begin
          nx[cpu_idx] = cpu_wr ? ST_IM : ST_IS;
          pend_n = 1'b1;
          pidx_n = cpu_idx;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
      pending  <= 1'b0;
      pidx     <= '0;
      cpu_done <= 1'b0;
      iss_vld  <= 1'b0;
      iss_cmd  <= C_RD;
      iss_idx  <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) st[i] <= nx[i];
      pending  <= pend_n;
      pidx     <= pidx_n;
      cpu_done <= done_n;
      iss_vld  <= iss_n;
      iss_cmd  <= cmd_n;
      iss_idx  <= idx_n;
    end
  end
endmodule

// File: rtl/msi_snoop_chk.sv
module msi_snoop_chk #(
  parameter int LINES = 16,
  parameter int IW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_stall,
  input logic          cpu_done,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          iss_vld,
  input logic [1:0]    iss_cmd,
  input logic [IW-1:0] iss_idx,
  input logic          snp_vld,
  input logic [1:0]    snp_cmd,
  input logic [IW-1:0] snp_idx,
  input logic [2:0]    st [LINES]
);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  a_r11_issue_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> iss_vld && cpu_done && iss_cmd != 2'd3);
  a_r6_wb_on_modified: assert property (@(posedge clk) disable iff (!rst_n)
    snp_vld && snp_cmd != 2'd3 && st[snp_idx] == 3'd2
      |=> iss_vld && iss_cmd == 2'd3 && iss_idx == $past(snp_idx));
  a_r10_wb_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld && iss_cmd == 2'd3 |-> $past(snp_vld));
  a_r9_no_done_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall && !bus_gnt |=> !cpu_done);
  a_r2_req_from_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cpu_req));
endmodule

bind msi_snoop_ctrl msi_snoop_chk #(.LINES(LINES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
  .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .iss_vld(iss_vld), .iss_cmd(iss_cmd), .iss_idx(iss_idx),
  .snp_vld(snp_vld), .snp_cmd(snp_cmd), .snp_idx(snp_idx), .st(st));

// File: tb/sim_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_msi_snoop_ctrl;
  localparam int LINES = 16;
  localparam int IW = 4;
  localparam int I = 0, S = 1, M = 2, IS = 3, IM = 4, SM = 5;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_wr = 0, bus_gnt = 0, snp_vld = 0;
  logic [IW-1:0] cpu_idx = 0, snp_idx = 0;
  logic [1:0] snp_cmd = 0;
  logic cpu_stall, cpu_done, bus_req, iss_vld;
  logic [1:0] iss_cmd;
  logic [IW-1:0] iss_idx;

  int checks = 0, fails = 0;
  int m [LINES];
  bit mp;
  int mpi;

  always #2.5 clk = ~clk;

  msi_snoop_ctrl #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .iss_vld(iss_vld), .iss_cmd(iss_cmd), .iss_idx(iss_idx),
    .snp_vld(snp_vld), .snp_cmd(snp_cmd), .snp_idx(snp_idx));

  function automatic int snoop_next(int s, int c);
    bit k = (c == 1) || (c == 2);
    if (c == 3) return s;
    if (s == M) return k ? I : S;
    if (s == S && k) return I;
    if (s == SM && k) return IM;
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit cr, bit cw, int ci, bit g, bit sv, int sc, int si);
    bit e_done = 0, e_iss = 0;
    int e_cmd = 0, e_idx = 0;
    @(negedge clk);
    cpu_req = cr; cpu_wr = cw; cpu_idx = ci[IW-1:0];
    bus_gnt = g; snp_vld = sv; snp_cmd = sc[1:0]; snp_idx = si[IW-1:0];
    if (sv) begin
      if (m[si] == M && sc != 3) begin e_iss = 1; e_cmd = 3; e_idx = si; end
      m[si] = snoop_next(m[si], sc);
    end
    if (mp && g) begin
      e_iss = 1; e_done = 1; e_idx = mpi; mp = 0;
      if (m[mpi] == IS) begin e_cmd = 0; m[mpi] = S; end
      else if (m[mpi] == SM) begin e_cmd = 2; m[mpi] = M; end
      else begin e_cmd = 1; m[mpi] = M; end
    end else if (cr && !mp) begin
      if (m[ci] == M || (m[ci] == S && !cw)) e_done = 1;
      else begin
        m[ci] = (m[ci] == S) ? SM : (cw ? IM : IS);
        mp = 1; mpi = ci;
      end
    end
    @(posedge clk); #1;
    chk(tag, cpu_done, e_done, "cpu_done");
    chk(tag, bus_req, mp, "bus_req");
    chk(tag, cpu_stall, mp, "cpu_stall");
    chk(tag, iss_vld, e_iss, "iss_vld");
    if (e_iss) begin
      chk(tag, iss_cmd, e_cmd, "iss_cmd");
      chk(tag, iss_idx, e_idx, "iss_idx");
    end
  endtask

  task automatic idle(string tag); step(tag, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(string tag, int i); step(tag, 1, 0, i, 0, 0, 0, 0); endtask
  task automatic wr(string tag, int i); step(tag, 1, 1, i, 0, 0, 0, 0); endtask
  task automatic gnt(string tag); step(tag, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic snp(string tag, int c, int i); step(tag, 0, 0, 0, 0, 1, c, i); endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) m[i] = I;
    mp = 0; mpi = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", bus_req, 0, "bus_req reset");
    chk("R1", cpu_stall, 0, "cpu_stall reset");
    chk("R1", cpu_done, 0, "cpu_done reset");
    chk("R1", iss_vld, 0, "iss_vld reset");
    @(negedge clk); rst_n = 1;
    rd("R1", 3); idle("R11"); idle("R11"); gnt("R2"); rd("R5", 3);
    wr("R3", 5); snp("R10", 0, 5); snp("R9", 1, 3); gnt("R3"); wr("R5", 5); rd("R5", 5);
    rd("R2", 3); gnt("R2"); wr("R4", 3); gnt("R4"); wr("R5", 3);
    snp("R6", 0, 3); rd("R6", 3); wr("R6", 3); gnt("R4");
    snp("R6", 1, 3); rd("R6", 3); gnt("R2");
    snp("R7", 0, 3); rd("R7", 3); snp("R7", 2, 3); rd("R7", 3); gnt("R2");
    wr("R8", 3); snp("R8", 1, 3); gnt("R8");
    rd("R8", 7); gnt("R2"); wr("R8", 7); snp("R8", 2, 7); idle("R8"); gnt("R8");
    snp("R10", 3, 7); wr("R10", 7);
    wr("R9", 9); wr("R9", 10); snp("R9", 0, 7); gnt("R9"); rd("R9", 10); gnt("R9");
    step("R11", 1, 0, 12, 0, 1, 1, 5); gnt("R11");
    step("R11", 1, 1, 12, 0, 1, 0, 12); gnt("R11");
    void'($urandom(32'd1357));
    for (int n = 0; n < 4000; n++) begin
      bit g = mp && ($urandom % 3 == 0);
      bit sv = !g && ($urandom % 3 == 0);
      step("R11", $urandom % 2, $urandom % 2, $urandom % 4, g, sv, $urandom % 4, $urandom % 4);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule